// File: doc/BRIEF.md
# Endpoint-Zero Control Request Handler

This block is the device-side logic for the default control pipe during enumeration. An upstream packet layer hands it an already decoded 8-byte request on a setup strobe. After that it raises one strobe for each data-stage IN token and one strobe for the status stage. The block decodes the standard requests it supports and serves descriptor bytes from a computed descriptor store. It returns reply data one byte per cycle, marks the last byte of each packet, and answers with a zero-length packet or a STALL handshake when one is due.

Inside the block sit the device address and the configured flag. A new address is held back until the status stage of its request is acknowledged. Descriptor replies are cut to whichever is shorter, the host's requested length or the descriptor's real length. A bus reset drops everything back to the default state, at any point in a transfer.

Top module: `ep0_ctrl_handler`

## Requirements
- R1: After `rst` or a one-cycle `bus_reset`, `dev_addr` is 0, `dev_configured` is 0, no reply bytes remain, and any stall condition is cleared. An IN request then yields `tx_zlp`.
- R2: A device descriptor request returns 18 bytes. The request is type 0x80, code 6, wValue high byte 1, wIndex 0. The bytes are: 18, 1, 0x00, 0x02, 0, 0, 0, PKT_MAX, VENDOR_ID low and high, PRODUCT_ID low and high, 0x00, 0x01, 0, 0, 0, 1.
- R3: A configuration request returns one contiguous tree of 9+9+7·NUM_EP bytes. The request is type 0x80, code 6, wValue 0x0200, wIndex 0. The header is 9, 2, total length low and high, 1, 1, 0, 0x80, 50. The interface is 9, 4, 0, 0, NUM_EP, 0xFF, 0, 0, 0. Each endpoint is 7, 5, address, 2, BULK_MPS low and high, 0.
- R4: The reply length is the smaller of wLength and the length of the selected item. No byte past it is ever sent.
- R5: Each `in_req` returns up to PKT_MAX bytes on consecutive cycles, with `tx_valid` high and `tx_last` on the final byte. The first byte appears one cycle after the request. An `in_req` with no reply bytes left returns `tx_zlp`. Such a zero-length packet is due when the reply is a multiple of PKT_MAX and shorter than wLength.
- R6: Set Address is type 0x00, code 5, with a value of at most 127. `dev_addr` keeps its old value until the status strobe is acknowledged. It takes the new value on the same cycle that `hs_ack` is high.
- R7: Set Configuration is type 0x00, code 9. Value 1 sets `dev_configured` and value 0 clears it, each on the status acknowledge. Any other value is stalled and changes nothing.
- R8: Get Configuration is type 0x80, code 8. It returns one byte: 1 when configured, otherwise 0.
- R9: An unsupported request type, code, descriptor type or value stalls the transfer. Each `in_req` then gives `tx_stall`, and the status strobe gives `hs_stall` with the state unchanged. The next setup strobe clears the stall.
- R10: Endpoint k (counted from 0) of the tree has number k+1. Address bit 7 is set (IN) for even k and clear (OUT) for odd k.
- R11: A bus reset during a data packet ends `tx_valid` on the next cycle and discards the rest of the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset detected by the line layer |
| setup_valid | input | 1 | Setup packet strobe |
| setup_data | input | 64 | Request: [7:0] type, [15:8] code, [31:16] wValue, [47:32] wIndex, [63:48] wLength |
| in_req | input | 1 | Data-stage IN token strobe |
| status_req | input | 1 | Status-stage strobe |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Last byte of the current packet |
| tx_zlp | output | 1 | Zero-length packet answer |
| tx_stall | output | 1 | STALL answer to an IN token |
| hs_ack | output | 1 | Status stage acknowledged |
| hs_stall | output | 1 | Status stage stalled |
| dev_addr | output | 7 | Current device address |
| dev_configured | output | 1 | Configured state |

## Verification
The hardest state to reach from the ports is a reply that ends exactly on a packet boundary while still shorter than the host asked for, because only that case needs a trailing zero-length packet. The bench builds the block with an 8-byte packet size, which makes the 32-byte configuration tree end on a boundary. It then sweeps wLength from 0 to 40 for both descriptors. Every cut-off, every partial final packet and every boundary case is visited this way, with packet sizes and byte values derived arithmetically. A second hard case, a bus reset landing in the middle of a packet, is reached by asserting the reset after the second byte has been observed.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DEV,
        SRC_CFG,
        SRC_CFGVAL
    } reply_src_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET_ADDR,
        ACT_SET_CFG
    } pend_act_e;

    // packed: first member is the most significant; req_type sits in bits [7:0]
    typedef struct packed {
        logic [15:0] length;
        logic [15:0] index;
        logic [15:0] value;
        logic [7:0]  request;
        logic [7:0]  req_type;
    } setup_pkt_t;

    typedef struct packed {
        pend_act_e   act;
        logic        stall;
        reply_src_e  src;
        logic [15:0] len;
        logic [7:0]  val;
    } req_decode_t;

    localparam logic [7:0] RT_STD_IN    = 8'h80;
    localparam logic [7:0] RT_STD_OUT   = 8'h00;
    localparam logic [7:0] REQ_SET_ADDR = 8'h05;
    localparam logic [7:0] REQ_GET_DESC = 8'h06;
    localparam logic [7:0] REQ_GET_CFG  = 8'h08;
    localparam logic [7:0] REQ_SET_CFG  = 8'h09;
    localparam logic [7:0] DT_DEVICE    = 8'h01;
    localparam logic [7:0] DT_CONFIG    = 8'h02;
    localparam logic [7:0] CFG_VALUE    = 8'h01;

    localparam int DEV_DESC_LEN = 18;
    localparam int CFG_HDR_LEN  = 9;
    localparam int IF_DESC_LEN  = 9;
    localparam int EP_DESC_LEN  = 7;
    localparam int EP_BASE      = CFG_HDR_LEN + IF_DESC_LEN;

    function automatic logic [15:0] clip_len(input logic [15:0] want,
                                             input logic [15:0] have);
        return (want < have) ? want : have;
    endfunction

    function automatic logic [15:0] cfg_total(input int num_ep);
        return 16'(EP_BASE + EP_DESC_LEN * num_ep);
    endfunction

endpackage

// File: rtl/ep0_req_decode.sv
module ep0_req_decode
    import usbctl_pkg::*;
#(
    parameter int NUM_EP = 2
) (
    input  setup_pkt_t  pkt,
    output req_decode_t dec
);
    localparam logic [15:0] DEV_LEN16 = 16'(DEV_DESC_LEN);
    localparam logic [15:0] CFG_LEN16 = cfg_total(NUM_EP);

    logic idx_zero;
    assign idx_zero = (pkt.index == 16'h0000);

    always_comb begin
        dec.act   = ACT_NONE;
        dec.stall = 1'b1;
        dec.src   = SRC_NONE;
        dec.len   = 16'h0000;
        dec.val   = pkt.value[7:0];
        unique case (pkt.request)
            REQ_GET_DESC: begin
                if (pkt.req_type == RT_STD_IN && idx_zero) begin
                    if (pkt.value[15:8] == DT_DEVICE) begin
                        dec.stall = 1'b0;
                        dec.src   = SRC_DEV;
                        dec.len   = clip_len(pkt.length, DEV_LEN16);
                    end else if (pkt.value[15:8] == DT_CONFIG && pkt.value[7:0] == 8'h00) begin
                        dec.stall = 1'b0;
                        dec.src   = SRC_CFG;
                        dec.len   = clip_len(pkt.length, CFG_LEN16);
                    end
                end
            end
            REQ_GET_CFG: begin
                if (pkt.req_type == RT_STD_IN && idx_zero && pkt.value == 16'h0000) begin
                    dec.stall = 1'b0;
                    dec.src   = SRC_CFGVAL;
                    dec.len   = clip_len(pkt.length, 16'd1);
                end
            end
            REQ_SET_ADDR: begin
                if (pkt.req_type == RT_STD_OUT && idx_zero && pkt.value[15:7] == 9'h000) begin
                    dec.stall = 1'b0;
                    dec.act   = ACT_SET_ADDR;
                end
            end
            REQ_SET_CFG: begin
                if (pkt.req_type == RT_STD_OUT && idx_zero && pkt.value[15:8] == 8'h00 &&
                    (pkt.value[7:0] == 8'h00 || pkt.value[7:0] == CFG_VALUE)) begin
                    dec.stall = 1'b0;
                    dec.act   = ACT_SET_CFG;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ep0_desc_rom.sv
module ep0_desc_rom
    import usbctl_pkg::*;
#(
    parameter int          PKT_MAX    = 64,
    parameter int          NUM_EP     = 2,
    parameter logic [15:0] VENDOR_ID  = 16'hABCD,
    parameter logic [15:0] PRODUCT_ID = 16'h0102,
    parameter int          BULK_MPS   = 512
) (
    input  reply_src_e  src,
    input  logic [15:0] idx,
    input  logic        configured,
    output logic [7:0]  data
);
    localparam logic [15:0] CFG_LEN16 = cfg_total(NUM_EP);
    localparam logic [15:0] MPS16     = 16'(BULK_MPS);

    logic [7:0] dev_byte;
    logic [7:0] head_byte;
    logic [7:0] ep_byte [NUM_EP];
    logic [NUM_EP-1:0] ep_hit;

    always_comb begin
        dev_byte = 8'h00;
        if (idx < 16'(DEV_DESC_LEN)) begin
            case (idx[4:0])
                5'd0:  dev_byte = 8'(DEV_DESC_LEN);
                5'd1:  dev_byte = DT_DEVICE;
                5'd3:  dev_byte = 8'h02;
                5'd7:  dev_byte = 8'(PKT_MAX);
                5'd8:  dev_byte = VENDOR_ID[7:0];
                5'd9:  dev_byte = VENDOR_ID[15:8];
                5'd10: dev_byte = PRODUCT_ID[7:0];
                5'd11: dev_byte = PRODUCT_ID[15:8];
                5'd13: dev_byte = 8'h01;
                5'd17: dev_byte = 8'h01;
                default: dev_byte = 8'h00;
            endcase
        end
    end

    always_comb begin
        head_byte = 8'h00;
        if (idx < 16'(EP_BASE)) begin
            case (idx[4:0])
                5'd0:  head_byte = 8'(CFG_HDR_LEN);
                5'd1:  head_byte = DT_CONFIG;
                5'd2:  head_byte = CFG_LEN16[7:0];
                5'd3:  head_byte = CFG_LEN16[15:8];
                5'd4:  head_byte = 8'h01;
                5'd5:  head_byte = CFG_VALUE;
                5'd7:  head_byte = 8'h80;
                5'd8:  head_byte = 8'd50;
                5'd9:  head_byte = 8'(IF_DESC_LEN);
                5'd10: head_byte = 8'h04;
                5'd13: head_byte = 8'(NUM_EP);
                5'd14: head_byte = 8'hFF;
                default: head_byte = 8'h00;
            endcase
        end
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        localparam logic [15:0] BASE  = 16'(EP_BASE + EP_DESC_LEN * e);
        localparam logic [7:0]  EADDR = ((e % 2) == 0) ? 8'(8'h80 | (e + 1)) : 8'(e + 1);
        logic [15:0] off;
        assign off       = idx - BASE;
        assign ep_hit[e] = (idx >= BASE) && (idx < BASE + 16'(EP_DESC_LEN));
        always_comb begin
            case (off[2:0])
                3'd0: ep_byte[e] = 8'(EP_DESC_LEN);
                3'd1: ep_byte[e] = 8'h05;
                3'd2: ep_byte[e] = EADDR;
                3'd3: ep_byte[e] = 8'h02;
                3'd4: ep_byte[e] = MPS16[7:0];
                3'd5: ep_byte[e] = MPS16[15:8];
                default: ep_byte[e] = 8'h00;
            endcase
        end
    end

    always_comb begin
        data = 8'h00;
        unique case (src)
            SRC_DEV:    data = dev_byte;
            SRC_CFGVAL: data = {7'h00, configured};
            SRC_CFG: begin
                data = head_byte;
                for (int e = 0; e < NUM_EP; e++) begin
                    if (ep_hit[e]) data = ep_byte[e];
                end
            end
            default: data = 8'h00;
        endcase
    end

endmodule

// File: rtl/ep0_tx_stream.sv
module ep0_tx_stream
    import usbctl_pkg::*;
#(
    parameter int PKT_MAX = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  reply_src_e  load_src,
    input  logic [15:0] load_len,
    input  logic        start,
    output reply_src_e  rom_src,
    output logic [15:0] rom_idx,
    input  logic [7:0]  rom_byte,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        tx_zlp,
    output logic        busy
);
    localparam int          CNT_W = $clog2(PKT_MAX + 1);
    localparam logic [15:0] PKT16 = 16'(PKT_MAX);

    reply_src_e       src_q;
    logic [15:0]      ptr_q;
    logic [15:0]      remain_q;
    logic [CNT_W-1:0] pkt_left_q;
    logic             streaming_q;
    logic             zlp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q       <= SRC_NONE;
            ptr_q       <= 16'h0000;
            remain_q    <= 16'h0000;
            pkt_left_q  <= '0;
            streaming_q <= 1'b0;
            zlp_q       <= 1'b0;
        end else begin
            zlp_q <= 1'b0;
            if (load) begin
                src_q       <= load_src;
                ptr_q       <= 16'h0000;
                remain_q    <= load_len;
                streaming_q <= 1'b0;
            end else if (streaming_q) begin
                ptr_q      <= ptr_q + 16'd1;
                remain_q   <= remain_q - 16'd1;
                pkt_left_q <= pkt_left_q - CNT_W'(1);
                if (pkt_left_q == CNT_W'(1)) streaming_q <= 1'b0;
            end else if (start) begin
                if (remain_q == 16'h0000) begin
                    zlp_q <= 1'b1;
                end else begin
                    streaming_q <= 1'b1;
                    pkt_left_q  <= (remain_q > PKT16) ? CNT_W'(PKT_MAX) : CNT_W'(remain_q);
                end
            end
        end
    end

    assign rom_src  = src_q;
    assign rom_idx  = ptr_q;
    assign tx_valid = streaming_q;
    assign tx_data  = streaming_q ? rom_byte : 8'h00;
    assign tx_last  = streaming_q && (pkt_left_q == CNT_W'(1));
    assign tx_zlp   = zlp_q;
    assign busy     = streaming_q;

    // R5
    pkt_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last && !load) |=> tx_valid);

    // R4
    remain_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (remain_q <= $past(remain_q)));

    // R5
    zlp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_zlp && tx_valid));

endmodule

// File: rtl/ep0_ctrl_handler.sv
module ep0_ctrl_handler
    import usbctl_pkg::*;
#(
    parameter int          PKT_MAX    = 64,
    parameter int          NUM_EP     = 2,
    parameter logic [15:0] VENDOR_ID  = 16'hABCD,
    parameter logic [15:0] PRODUCT_ID = 16'h0102,
    parameter int          BULK_MPS   = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        setup_valid,
    input  logic [63:0] setup_data,
    input  logic        in_req,
    input  logic        status_req,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        tx_zlp,
    output logic        tx_stall,
    output logic        hs_ack,
    output logic        hs_stall,
    output logic [6:0]  dev_addr,
    output logic        dev_configured
);
    logic        rst_any;
    req_decode_t dec;
    reply_src_e  rom_src;
    logic [15:0] rom_idx;
    logic [7:0]  rom_byte;
    logic        busy;
    logic        start;

    logic        stall_q;
    pend_act_e   pend_q;
    logic [7:0]  pend_val_q;
    logic [6:0]  addr_q;
    logic        cfg_q;
    logic        tx_stall_q;
    logic        hs_ack_q;
    logic        hs_stall_q;

    assign rst_any = rst | bus_reset;
    assign start   = in_req && !stall_q && !busy;

    ep0_req_decode #(.NUM_EP(NUM_EP)) u_dec (
        .pkt (setup_pkt_t'(setup_data)),
        .dec (dec)
    );

    ep0_desc_rom #(
        .PKT_MAX(PKT_MAX), .NUM_EP(NUM_EP), .VENDOR_ID(VENDOR_ID),
        .PRODUCT_ID(PRODUCT_ID), .BULK_MPS(BULK_MPS)
    ) u_rom (
        .src        (rom_src),
        .idx        (rom_idx),
        .configured (cfg_q),
        .data       (rom_byte)
    );

    ep0_tx_stream #(.PKT_MAX(PKT_MAX)) u_stream (
        .clk      (clk),
        .rst      (rst_any),
        .load     (setup_valid),
        .load_src (dec.stall ? SRC_NONE : dec.src),
        .load_len (dec.stall ? 16'h0000 : dec.len),
        .start    (start),
        .rom_src  (rom_src),
        .rom_idx  (rom_idx),
        .rom_byte (rom_byte),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_zlp   (tx_zlp),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst_any) begin
            stall_q    <= 1'b0;
            pend_q     <= ACT_NONE;
            pend_val_q <= 8'h00;
            addr_q     <= 7'h00;
            cfg_q      <= 1'b0;
            tx_stall_q <= 1'b0;
            hs_ack_q   <= 1'b0;
            hs_stall_q <= 1'b0;
        end else begin
            tx_stall_q <= 1'b0;
            hs_ack_q   <= 1'b0;
            hs_stall_q <= 1'b0;
            if (setup_valid) begin
                stall_q    <= dec.stall;
                pend_q     <= dec.stall ? ACT_NONE : dec.act;
                pend_val_q <= dec.val;
            end else begin
                if (in_req && stall_q) tx_stall_q <= 1'b1;
                if (status_req) begin
                    if (stall_q) begin
                        hs_stall_q <= 1'b1;
                    end else begin
                        hs_ack_q <= 1'b1;
                        pend_q   <= ACT_NONE;
                        unique case (pend_q)
                            ACT_SET_ADDR: addr_q <= pend_val_q[6:0];
                            ACT_SET_CFG:  cfg_q  <= (pend_val_q != 8'h00);
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign tx_stall       = tx_stall_q;
    assign hs_ack         = hs_ack_q;
    assign hs_stall       = hs_stall_q;
    assign dev_addr       = addr_q;
    assign dev_configured = cfg_q;

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(status_req) && !$past(bus_reset)) |-> $stable(dev_addr));

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (dev_addr == 7'h00 && !dev_configured && !tx_valid));

    // R7
    cfg_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dev_configured) && !$past(bus_reset)) |-> hs_ack);

    // R9
    answer_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_valid, tx_zlp, tx_stall}));

    // R9
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hs_ack && hs_stall));

endmodule

// File: tb/tb_ep0_ctrl_handler.sv
module tb_ep0_ctrl_handler;
    localparam int CLK_PERIOD = 10;
    localparam int PKT        = 8;
    localparam int NEP        = 2;
    localparam int CFG_LEN    = 18 + 7 * NEP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset = 1'b0;
    logic        setup_valid = 1'b0;
    logic [63:0] setup_data = 64'h0;
    logic        in_req = 1'b0;
    logic        status_req = 1'b0;
    logic        tx_valid, tx_last, tx_zlp, tx_stall, hs_ack, hs_stall, dev_configured;
    logic [7:0]  tx_data;
    logic [6:0]  dev_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] buf_q [0:31];
    int  n_got;
    bit  got_zlp, got_stall, got_ack, got_hstall;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep0_ctrl_handler #(.PKT_MAX(PKT), .NUM_EP(NEP)) dut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .setup_valid(setup_valid),
        .setup_data(setup_data), .in_req(in_req), .status_req(status_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
        .tx_stall(tx_stall), .hs_ack(hs_ack), .hs_stall(hs_stall),
        .dev_addr(dev_addr), .dev_configured(dev_configured)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_dev(input int i);
        case (i)
            0: return 18;  1: return 1;  3: return 2;  7: return PKT;
            8: return 8'hCD; 9: return 8'hAB; 10: return 8'h02; 11: return 8'h01;
            13: return 1; 17: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cfg(input int i);
        int e, o;
        if (i < 18) begin
            case (i)
                0: return 9;  1: return 2;  2: return CFG_LEN;  4: return 1;  5: return 1;
                7: return 8'h80; 8: return 50; 9: return 9; 10: return 4; 13: return NEP;
                14: return 8'hFF;
                default: return 0;
            endcase
        end
        e = (i - 18) / 7;
        o = (i - 18) % 7;
        case (o)
            0: return 7;
            1: return 5;
            2: return (e % 2 == 0) ? (8'h80 + e + 1) : (e + 1);
            3: return 2;
            5: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic setup(input logic [7:0] rt, input logic [7:0] rq,
                         input logic [15:0] val, input logic [15:0] len);
        @(negedge clk);
        setup_valid = 1'b1;
        setup_data  = {len, 16'h0000, val, rq, rt};
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic read_pkt();
        n_got = 0; got_zlp = 0; got_stall = 0;
        @(negedge clk);
        in_req = 1'b1;
        @(negedge clk);
        in_req = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (tx_zlp) begin got_zlp = 1; break; end
            if (tx_stall) begin got_stall = 1; break; end
            if (tx_valid) begin
                if (n_got < 32) buf_q[n_got] = tx_data;
                n_got++;
                if (tx_last) break;
            end else if (k > 0) break;
            @(negedge clk);
        end
    endtask

    task automatic status();
        @(negedge clk);
        status_req = 1'b1;
        @(negedge clk);
        status_req = 1'b0;
        got_ack = hs_ack;
        got_hstall = hs_stall;
    endtask

    task automatic sweep(input int dtype);
        int dlen, tot, got, sz;
        dlen = (dtype == 1) ? 18 : CFG_LEN;
        for (int wl = 0; wl <= 40; wl++) begin
            tot = (wl < dlen) ? wl : dlen;
            got = 0;
            setup(8'h80, 8'h06, {8'(dtype), 8'h00}, 16'(wl));
            while (got < tot) begin
                read_pkt();
                sz = ((tot - got) < PKT) ? (tot - got) : PKT;
                // R5 packet size, R4 truncation
                chk(n_got == sz, "R5 packet size", n_got, sz);
                for (int b = 0; b < n_got && b < sz; b++) begin
                    if (dtype == 1)
                        chk(buf_q[b] == 8'(exp_dev(got + b)), "R2 device byte", buf_q[b], exp_dev(got + b));
                    else
                        chk(buf_q[b] == 8'(exp_cfg(got + b)), "R3 config byte", buf_q[b], exp_cfg(got + b));
                end
                if (n_got == 0) begin
                    chk(0, "R4 reply ended early", got, tot);
                    break;
                end
                got += sz;
            end
            if ((tot % PKT) == 0 && tot < wl) begin
                read_pkt();
                chk(got_zlp && n_got == 0, "R5 zero-length packet", n_got, 0);
            end
            status();
            chk(got_ack, "R4 status ack", got_ack, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(dev_addr == 0, "R1 reset address", dev_addr, 0);
        chk(!dev_configured, "R1 reset config", dev_configured, 0);
        read_pkt();
        chk(got_zlp, "R1 no pending reply", got_zlp, 1);

        sweep(1);
        sweep(2);

        // R10 endpoint directions
        setup(8'h80, 8'h06, 16'h0200, 16'd64);
        read_pkt(); read_pkt(); read_pkt();
        chk(buf_q[4] == 8'h81, "R10 ep0 address IN", buf_q[4], 8'h81);
        read_pkt();
        chk(buf_q[3] == 8'h02, "R10 ep1 address OUT", buf_q[3], 8'h02);
        status();

        // R6 deferred address
        setup(8'h00, 8'h05, 16'h002A, 16'd0);
        chk(dev_addr == 0, "R6 address before status", dev_addr, 0);
        read_pkt();
        chk(got_zlp && dev_addr == 0, "R6 address during data", dev_addr, 0);
        status();
        chk(got_ack && dev_addr == 7'h2A, "R6 address after status", dev_addr, 7'h2A);

        // R8 get configuration unconfigured
        setup(8'h80, 8'h08, 16'h0000, 16'd1);
        read_pkt();
        chk(n_got == 1 && buf_q[0] == 8'h00, "R8 config byte 0", buf_q[0], 0);
        status();

        // R7 and R9: invalid configuration value
        setup(8'h00, 8'h09, 16'h0003, 16'd0);
        read_pkt();
        chk(got_stall, "R9 stall on IN", got_stall, 1);
        status();
        chk(got_hstall && !got_ack, "R7 bad config stalled", got_hstall, 1);
        chk(!dev_configured, "R7 bad config no effect", dev_configured, 0);

        // R9 unsupported descriptor type
        setup(8'h80, 8'h06, 16'h0300, 16'd16);
        read_pkt();
        chk(got_stall, "R9 string desc stalled", got_stall, 1);
        read_pkt();
        chk(got_stall, "R9 stall persists", got_stall, 1);
        status();
        chk(got_hstall, "R9 status stalled", got_hstall, 1);

        // R7 valid config; R9 stall cleared by new setup
        setup(8'h00, 8'h09, 16'h0001, 16'd0);
        chk(!dev_configured, "R7 config before status", dev_configured, 0);
        status();
        chk(got_ack && dev_configured, "R7 configured", dev_configured, 1);

        // R8 configured value
        setup(8'h80, 8'h08, 16'h0000, 16'd4);
        read_pkt();
        chk(n_got == 1 && buf_q[0] == 8'h01, "R8 config byte 1", buf_q[0], 1);
        status();

        // R9 class request, R9 too-large address
        setup(8'h21, 8'h09, 16'h0001, 16'd0);
        status();
        chk(got_hstall && dev_configured, "R9 class request stalled", got_hstall, 1);
        setup(8'h00, 8'h05, 16'h00C8, 16'd0);
        status();
        chk(got_hstall && dev_addr == 7'h2A, "R9 address 200 stalled", dev_addr, 7'h2A);

        // R7 value 0 returns to addressed
        setup(8'h00, 8'h09, 16'h0000, 16'd0);
        status();
        chk(!dev_configured && dev_addr == 7'h2A, "R7 deconfigure", dev_configured, 0);

        // R11 bus reset mid packet
        setup(8'h00, 8'h09, 16'h0001, 16'd0);
        status();
        setup(8'h80, 8'h06, 16'h0200, 16'd32);
        @(negedge clk);
        in_req = 1'b1;
        @(negedge clk);
        in_req = 1'b0;
        chk(tx_valid && tx_data == 8'h09, "R11 first byte", tx_data, 9);
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        chk(!tx_valid, "R11 stream cut", tx_valid, 0);
        chk(dev_addr == 0 && !dev_configured, "R1 bus reset default", dev_addr, 0);
        read_pkt();
        chk(got_zlp && n_got == 0, "R11 reply discarded", n_got, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule